// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the system-side master for an external 8-bit serial analog-to-digital converter that has an addressable input multiplexer. A conversion is requested through a valid/ready request port that carries the mode (single-ended or differential), the polarity/odd bit and a two-bit pair/channel select. The block lowers the active-low chip select and derives the serial clock from the system clock with a parameterised divider. On that clock it sends a start bit and the four address bits, allows one settling clock, and then reads the result.

The converter sends the result twice. The first copy comes most significant bit first. The second copy is a replay with the least significant bit first, and that bit is shared with the first copy. The block keeps the first copy as the result and compares the other seven bits with the replay. It reports the result with a mismatch flag on a valid/ready result port. Back-pressure works as follows. The result is held unchanged for as long as `res_ready` is low. No new request is accepted until the result has been taken and chip select has been high for the minimum gap, so the request port's `req_ready` stays low for that whole time.

Top module: `sadc_host`

## Requirements
- R1: `req_ready` is high only when no transfer is running, no result is pending and the inter-transfer gap has elapsed. A request is accepted on a clock edge with `req_valid` and `req_ready` both high. Request fields that change while a transfer is running have no effect on that transfer.
- R2: In the cycle after acceptance, `adc_cs_n` is low, `adc_sclk` is low and `adc_di` is 1 (the start bit). The first rising edge of `adc_sclk` comes HALF_DIV cycles later.
- R3: `adc_di` is 1 for rising edge 1, then `req_single`, `req_odd`, `req_sel[1]` and `req_sel[0]` for rising edges 2 to 5, and 0 for later edges. It changes only on falling edges, so it is stable for half a serial period before and after every rising edge.
- R4: `adc_sclk` high and low phases are each HALF_DIV system cycles long. The resulting clock lies between 10 kHz and 400 kHz, and no high phase lasts longer than 60 µs.
- R5: A transfer has exactly 21 rising edges. `adc_cs_n` returns high together with the falling edge that follows the 21st rising edge.
- R6: `adc_do` sampled on rising edges 7 to 14 gives `res_data`, with the most significant bit first.
- R7: `adc_do` sampled on rising edges 15 to 21 gives bits 1 to 7 of the replay. `res_mismatch` is 1 when any of them differs from the same bit of `res_data`.
- R8: `res_valid` rises in the same cycle that `adc_cs_n` rises. It stays high, with `res_data` and `res_mismatch` stable, until a cycle with `res_ready` high.
- R9: `adc_cs_n` stays high for at least 2*HALF_DIV system cycles between transfers.
- R10: During reset, `adc_cs_n`=1, `adc_sclk`=0, `adc_di`=0, `res_valid`=0 and `req_ready`=1.
- R11: `adc_sclk` is low whenever `adc_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request valid |
| req_ready | output | 1 | Request can be accepted |
| req_single | input | 1 | 1 = single-ended input, 0 = differential pair |
| req_odd | input | 1 | Odd channel / pair polarity bit |
| req_sel | input | 2 | Channel or pair select |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | DATA_W | Converted value |
| res_mismatch | output | 1 | Replay disagreed with the first copy |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_di | output | 1 | Serial start bit and address to the converter |
| adc_do | input | 1 | Serial data from the converter |

## Verification
The assertions assume that the converter changes `adc_do` only after a falling serial-clock edge, and that `res_ready` and the request fields may change in any cycle. The bench's converter model meets the first assumption: it drives a new bit only on falling edges of `adc_sclk`. The bench moves its inputs just after the rising system-clock edge. It also changes the request fields, and holds `req_valid` high, while a transfer is running. It stalls `res_ready` for different lengths of time, so that the hold and no-effect rules are exercised.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_HOLD} sadc_state_e;
  // start bit is edge 1, then this many address bits
  localparam int unsigned ADDR_W       = 4;
  // clocks allowed for multiplexer settling before data
  localparam int unsigned SETTLE_EDGES = 1;
endpackage

// File: rtl/sadc_clkgen.sv
module sadc_clkgen #(
  parameter int unsigned HALF_DIV = 20
)(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] WRAP_AT = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = run && (cnt == WRAP_AT);
  assign rise_tick = wrap && !sclk;
  assign fall_tick = wrap && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int unsigned DATA_W = 8
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      msb_en,
  input  logic                      rep_en,
  input  logic [$clog2(DATA_W)-1:0] rep_idx,
  input  logic                      din,
  output logic [DATA_W-1:0]         data,
  output logic                      mismatch
);
  localparam int unsigned IW = $clog2(DATA_W);

  logic [DATA_W-1:0] msb_sr;
  logic [DATA_W-1:1] rep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      msb_sr <= '0;
    else if (msb_en) msb_sr <= {msb_sr[DATA_W-2:0], din};
  end

  for (genvar i = 1; i < DATA_W; i++) begin : g_rep
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rep[i] <= 1'b0;
      else if (rep_en && rep_idx == IW'(i))    rep[i] <= din;
    end
  end

  assign data     = msb_sr;
  assign mismatch = (rep != msb_sr[DATA_W-1:1]);
endmodule

// File: rtl/sadc_host.sv
module sadc_host
  import sadc_pkg::*;
#(
  parameter int unsigned SYS_HZ   = 10_000_000,
  parameter int unsigned HALF_DIV = 20,
  parameter int unsigned DATA_W   = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_single,
  input  logic              req_odd,
  input  logic [1:0]        req_sel,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_mismatch,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              adc_di,
  input  logic              adc_do
);
  localparam int unsigned ADDR_LAST = 1 + ADDR_W;
  localparam int unsigned MSB_FIRST = ADDR_LAST + SETTLE_EDGES + 1;
  localparam int unsigned MSB_LAST  = MSB_FIRST + DATA_W - 1;
  localparam int unsigned REP_FIRST = MSB_LAST + 1;
  localparam int unsigned LAST_EDGE = MSB_LAST + DATA_W - 1;
  localparam int unsigned EW        = $clog2(LAST_EDGE + 1);
  localparam int unsigned IW        = $clog2(DATA_W);
  localparam int unsigned AIW       = $clog2(ADDR_W);
  localparam int unsigned GAP       = 2 * HALF_DIV;
  localparam int unsigned GW        = $clog2(GAP + 1);

  localparam logic [EW-1:0] ADDR_LAST_E = EW'(ADDR_LAST);
  localparam logic [EW-1:0] MSB_FIRST_E = EW'(MSB_FIRST);
  localparam logic [EW-1:0] MSB_LAST_E  = EW'(MSB_LAST);
  localparam logic [EW-1:0] REP_FIRST_E = EW'(REP_FIRST);
  localparam logic [EW-1:0] LAST_E      = EW'(LAST_EDGE);
  localparam logic [GW-1:0] GAP_G       = GW'(GAP);

  sadc_state_e       state;
  logic [EW-1:0]     edge_cnt;
  logic [EW-1:0]     k_next;
  logic [ADDR_W-1:0] addr_q;
  logic [GW-1:0]     gap_cnt;
  logic              cs_n_q;
  logic              di_q;
  logic              rise_tick;
  logic              fall_tick;
  logic              msb_en;
  logic              rep_en;
  logic [IW-1:0]     rep_idx;

  // serial value launched for a given rising edge number
  function automatic logic bit_for(input logic [EW-1:0] k, input logic [ADDR_W-1:0] a);
    if (k == EW'(1)) return 1'b1;
    if (k >= EW'(2) && k <= ADDR_LAST_E) return a[AIW'(ADDR_LAST_E - k)];
    return 1'b0;
  endfunction

  sadc_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (state == ST_XFER),
    .sclk      (adc_sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  assign k_next  = edge_cnt + EW'(1);
  assign msb_en  = rise_tick && (k_next >= MSB_FIRST_E) && (k_next <= MSB_LAST_E);
  assign rep_en  = rise_tick && (k_next >= REP_FIRST_E);
  assign rep_idx = IW'(k_next - MSB_LAST_E);

  sadc_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .msb_en   (msb_en),
    .rep_en   (rep_en),
    .rep_idx  (rep_idx),
    .din      (adc_do),
    .data     (res_data),
    .mismatch (res_mismatch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      addr_q   <= '0;
      gap_cnt  <= GAP_G;
      cs_n_q   <= 1'b1;
      di_q     <= 1'b0;
    end else begin
      if (cs_n_q && gap_cnt != GAP_G) gap_cnt <= gap_cnt + GW'(1);
      unique case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            state    <= ST_XFER;
            cs_n_q   <= 1'b0;
            di_q     <= 1'b1;
            edge_cnt <= '0;
            addr_q   <= {req_single, req_odd, req_sel};
            gap_cnt  <= '0;
          end
        end
        ST_XFER: begin
          if (rise_tick) edge_cnt <= k_next;
          if (fall_tick) begin
            if (edge_cnt == LAST_E) begin
              state   <= ST_HOLD;
              cs_n_q  <= 1'b1;
              di_q    <= 1'b0;
              gap_cnt <= '0;
            end else begin
              di_q <= bit_for(k_next, addr_q);
            end
          end
        end
        ST_HOLD: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE) && (gap_cnt == GAP_G);
  assign res_valid = (state == ST_HOLD);
  assign adc_cs_n  = cs_n_q;
  assign adc_di    = di_q;
endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk #(
  parameter int unsigned SYS_HZ   = 10_000_000,
  parameter int unsigned HALF_DIV = 20,
  parameter int unsigned DATA_W   = 8
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic              res_mismatch,
  input logic              adc_cs_n,
  input logic              adc_sclk,
  input logic              adc_di
);
  localparam int unsigned LAST_EDGE = 5 + 2 * DATA_W;
  localparam int unsigned GAP       = 2 * HALF_DIV;
  // 40% of the shortest legal period (2.5 us) is 1 us
  localparam int unsigned MIN_PH    = SYS_HZ / 1_000_000;
  // longest legal high time, 60 us
  localparam int unsigned MAX_HI    = 60 * (SYS_HZ / 1_000_000);
  localparam int unsigned SAT       = 32'hFFFF_FFF0;

  logic        sclk_d;
  int unsigned ph_len;
  int unsigned hi_len;
  int unsigned rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      ph_len <= 0;
      hi_len <= GAP;
      rises  <= 0;
    end else begin
      sclk_d <= adc_sclk;
      if (adc_sclk != sclk_d) ph_len <= 1;
      else if (ph_len < SAT)  ph_len <= ph_len + 1;
      if (!adc_cs_n)          hi_len <= 0;
      else if (hi_len < SAT)  hi_len <= hi_len + 1;
      if (adc_cs_n)                      rises <= 0;
      else if (adc_sclk && !sclk_d)      rises <= rises + 1;
    end
  end

  // R4
  sclk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sclk) |-> (ph_len >= MIN_PH && ph_len <= MAX_HI));
  // R4
  sclk_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sclk) |-> (ph_len >= MIN_PH));
  // R11
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);
  // R3
  di_launch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_di) |-> !adc_sclk);
  // R2
  cs_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sclk) |-> (!adc_cs_n && $past(!adc_cs_n)));
  // R5
  edge_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> (rises == LAST_EDGE && $past(adc_sclk) && !adc_sclk));
  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> (hi_len >= GAP));
  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_mismatch)));
  // R8
  res_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $rose(adc_cs_n));
  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n || res_valid) |-> !req_ready);
endmodule

bind sadc_host sadc_host_chk #(
  .SYS_HZ   (SYS_HZ),
  .HALF_DIV (HALF_DIV),
  .DATA_W   (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_data     (res_data),
  .res_mismatch (res_mismatch),
  .adc_cs_n     (adc_cs_n),
  .adc_sclk     (adc_sclk),
  .adc_di       (adc_di)
);

// File: tb/sim_sadc_host.sv
module sim_sadc_host;
  localparam int CLK_PERIOD = 10;
  localparam int H    = 20;
  localparam int DW   = 8;
  localparam int LAST = 21;
  localparam int TX   = 2 * LAST * H;
  localparam int GAP  = 2 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic req_valid = 1'b0, req_single = 1'b0, req_odd = 1'b0;
  logic [1:0] req_sel = 2'b00;
  logic res_ready = 1'b0;
  logic adc_do = 1'b0;
  logic req_ready, res_valid, res_mismatch, adc_cs_n, adc_sclk, adc_di;
  logic [DW-1:0] res_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  logic [DW-1:0] cur_data = '0;
  bit cur_corrupt = 0;

  // reference model state
  bit busy = 0, pend = 0;
  int t = 0, hi = GAP;
  bit m_single, m_odd;
  bit [1:0] m_sel;
  logic [DW-1:0] m_data;
  bit m_mis;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadc_host #(.SYS_HZ(10_000_000), .HALF_DIV(H), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_single(req_single), .req_odd(req_odd), .req_sel(req_sel),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_mismatch(res_mismatch), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_di(adc_di), .adc_do(adc_do)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_di(input int k);
    case (k)
      1: return 1;
      2: return int'(m_single);
      3: return int'(m_odd);
      4: return int'(m_sel[1]);
      5: return int'(m_sel[0]);
      default: return 0;
    endcase
  endfunction

  // behavioural converter: launches bits on falling serial-clock edges
  int rk = 0;
  always begin
    @(negedge adc_cs_n);
    rk = 0;
    while (!adc_cs_n) begin
      @(adc_sclk or adc_cs_n);
      if (adc_cs_n) break;
      if (adc_sclk) rk++;
      else if (rk >= 6 && rk <= 13) adc_do = cur_data[13 - rk];
      else if (rk >= 14 && rk <= 20) adc_do = cur_data[rk - 13] ^ (cur_corrupt && rk == 17);
      else adc_do = 1'b0;
    end
    adc_do = 1'b0;
  end

  // cycle-by-cycle reference, compared on every falling system-clock edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int e_cs, e_sclk, e_di, e_rr, e_rv;
      if (busy) begin
        int ph;
        ph = t / H;
        e_cs = 0; e_sclk = ph % 2; e_di = exp_di(ph / 2 + 1);
      end else begin
        e_cs = 1; e_sclk = 0; e_di = 0;
      end
      e_rv = int'(pend);
      e_rr = (!busy && !pend && hi >= GAP) ? 1 : 0;
      chk(busy ? ((t >= TX - 2*H) ? "R5 adc_cs_n" : "R2 adc_cs_n") : "R9 adc_cs_n", int'(adc_cs_n), e_cs);
      chk(busy ? "R4 adc_sclk" : "R11 adc_sclk", int'(adc_sclk), e_sclk);
      chk("R3 adc_di", int'(adc_di), e_di);
      chk("R8 res_valid", int'(res_valid), e_rv);
      chk("R1 req_ready", int'(req_ready), e_rr);
      if (pend) begin
        chk("R6 res_data", int'(res_data), int'(m_data));
        chk("R7 res_mismatch", int'(res_mismatch), int'(m_mis));
      end
      if (busy) begin
        t++;
        if (t == TX) begin busy = 0; pend = 1; hi = 0; end
      end else begin
        if (hi < GAP) hi++;
        if (pend && res_ready) pend = 0;
        if (e_rr == 1 && req_valid) begin
          busy = 1; t = 0;
          m_single = req_single; m_odd = req_odd; m_sel = req_sel;
          m_data = cur_data; m_mis = cur_corrupt;
        end
      end
    end
  end

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
      finish_sim();
    end
  end

  task automatic run_tx(input bit s, input bit o, input bit [1:0] sel,
                        input logic [DW-1:0] d, input bit bad,
                        input int stall, input bit hold_valid);
    @(posedge clk); #1;
    cur_data = d; cur_corrupt = bad;
    req_single = s; req_odd = o; req_sel = sel; req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    // R1: fields moved while busy must not reach adc_di
    if (hold_valid) begin req_single = ~s; req_odd = ~o; req_sel = ~sel; end
    else req_valid = 1'b0;
    @(negedge clk);
    while (!res_valid) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    repeat (stall) @(negedge clk);
    @(posedge clk); #1 res_ready = 1'b1;
    @(posedge clk); #1 res_ready = 1'b0;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #(3*CLK_PERIOD);
    // R10 reset values
    chk("R10 adc_cs_n", int'(adc_cs_n), 1);
    chk("R10 adc_sclk", int'(adc_sclk), 0);
    chk("R10 adc_di", int'(adc_di), 0);
    chk("R10 res_valid", int'(res_valid), 0);
    chk("R10 req_ready", int'(req_ready), 1);
    @(posedge clk); #1 rst_n = 1'b1;
    run_tx(1, 0, 2'b00, 8'hA5, 0, 0, 0);
    run_tx(1, 1, 2'b11, 8'h00, 0, 3, 0);
    run_tx(0, 0, 2'b00, 8'hFF, 0, 0, 1);
    run_tx(0, 1, 2'b10, 8'h81, 1, 0, 0);   // R7 corrupted replay
    run_tx(1, 0, 2'b01, 8'h3C, 0, 55, 0);  // R8 long back-pressure
    run_tx(0, 1, 2'b01, 8'h01, 0, 0, 1);
    run_tx(1, 1, 2'b01, 8'h80, 1, 7, 0);
    run_tx(1, 0, 2'b10, 8'h5A, 0, 0, 0);
    repeat (3*GAP) @(posedge clk);
    finish_sim();
  end
endmodule